// File: doc/BRIEF.md
# DMA Bring-Up Sequencer

This block replaces the processor's bare-metal setup code for a direct-register (non-descriptor) stream DMA engine. On a single `start` pulse it latches a source buffer address, a destination buffer address and a byte count. It then drives a fixed series of eight register writes over an AXI4-Lite master write port. It puts both channels into reset and waits a programmable number of cycles. Next it fully arms the stream-to-memory channel: destination address, run bit, then byte count. Only after that does it configure and launch the memory-to-stream channel: source address, run bit, then byte count. Because of this order, the receiving side is always ready before data starts to flow, and the loop cannot lock up.

Each write is a complete AXI4-Lite transaction. Address and data are offered together, each is held until accepted, and the response is then collected. Only one write is outstanding at a time. When the last write is acknowledged, `done` pulses for one cycle. A response other than OKAY halts the series and raises `error`, which stays high until the next `start`.

Top module: `dma_bringup_seq`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `m_awvalid`, `m_wvalid` and `m_bready` are all low.
- R2: The first two writes after `start` are reset requests. The first writes data 0x4 (bit 2 set) to REG_BASE+0x00 (read-channel control). The second writes 0x4 to REG_BASE+0x30 (write-channel control).
- R3: After the response to the second reset write is accepted at a clock edge, `m_awvalid` for the next write rises at edge `rst_wait`+2 counted from that edge.
- R4: Writes three to five arm the write channel, in this order: the latched destination address to REG_BASE+0x48, then 0x1 (bit 0 run) to REG_BASE+0x30, then the latched byte count (zero-extended) to REG_BASE+0x58.
- R5: Writes six to eight start the read channel, in this order: the latched source address to REG_BASE+0x18, then 0x1 to REG_BASE+0x00, then the byte count to REG_BASE+0x28. No ninth write follows.
- R6: `m_awvalid` and `m_wvalid` stay high with a stable payload until accepted. `m_bready` is high only after both have been accepted. A new write never starts before the previous response. `m_wstrb` is all ones.
- R7: `done` is high for exactly one cycle, at the edge after the final write's response is accepted, and `busy` is low at that time.
- R8: A write response other than 2'b00 (OKAY) stops the series. No further write is issued, `busy` falls, `error` rises at the edge of that response, and no `done` pulse follows.
- R9: While `busy` is high, `start` is ignored. Address and length inputs are latched at the accepted `start`, so later changes to them have no effect on the writes issued.
- R10: `start` while `error` is high clears `error` at the next edge and runs the full eight-write series again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the bring-up series (one-cycle pulse) |
| src_addr | input | DATA_W | Source buffer address for the read channel |
| dst_addr | input | DATA_W | Destination buffer address for the write channel |
| byte_len | input | LEN_W | Transfer length in bytes, used for both channels |
| rst_wait | input | WAIT_W | Extra cycles to wait after the reset writes |
| busy | output | 1 | Series in progress |
| done | output | 1 | One-cycle pulse when all writes have been acknowledged |
| error | output | 1 | A write response was not OKAY; held until next start |
| m_awaddr | output | ADDR_W | AXI4-Lite write address |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write byte strobes |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |

## Verification
The slave model in the bench raises `m_bvalid` at a falling edge, so the response is accepted at the next rising edge. Each completed write is compared against the scoreboard at that point, so order and payload are checked one write at a time, whatever ready and response delays the test uses. `done` is due one clock after the final response edge and `error` the same clock after a failing response. The bench therefore expects both at the first falling edge after that response. For the reset wait, the rising edge of the next `m_awvalid` is due `rst_wait`+2 edges after the reset response edge. Measured from the falling edge where `m_bvalid` was raised, that is `rst_wait`+3 cycles, and the bench compares the measured count to exactly that.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAITB,
    ST_DELAY,
    ST_ERROR
  } seq_state_t;

  localparam int N_STEPS       = 8;
  localparam int STEP_W        = $clog2(N_STEPS);
  localparam int STEP_LAST_RST = 1;

  localparam logic [7:0] OFF_RD_CTRL = 8'h00;
  localparam logic [7:0] OFF_RD_SRC  = 8'h18;
  localparam logic [7:0] OFF_RD_LEN  = 8'h28;
  localparam logic [7:0] OFF_WR_CTRL = 8'h30;
  localparam logic [7:0] OFF_WR_DST  = 8'h48;
  localparam logic [7:0] OFF_WR_LEN  = 8'h58;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_RST_BIT = 2;

  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/dbs_step_map.sv
module dbs_step_map
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 26,
  parameter logic [ADDR_W-1:0] REG_BASE = '0
) (
  input  logic [STEP_W-1:0] step,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] dst,
  input  logic [LEN_W-1:0]  len,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_data
);
  localparam logic [DATA_W-1:0] CTRL_RST = DATA_W'(1) << CTRL_RST_BIT;
  localparam logic [DATA_W-1:0] CTRL_RUN = DATA_W'(1) << CTRL_RUN_BIT;

  logic [7:0] offset;

  always_comb begin
    case (step)
      3'd0:    begin offset = OFF_RD_CTRL; reg_data = CTRL_RST;        end
      3'd1:    begin offset = OFF_WR_CTRL; reg_data = CTRL_RST;        end
      3'd2:    begin offset = OFF_WR_DST;  reg_data = dst;             end
      3'd3:    begin offset = OFF_WR_CTRL; reg_data = CTRL_RUN;        end
      3'd4:    begin offset = OFF_WR_LEN;  reg_data = DATA_W'(len);    end
      3'd5:    begin offset = OFF_RD_SRC;  reg_data = src;             end
      3'd6:    begin offset = OFF_RD_CTRL; reg_data = CTRL_RUN;        end
      default: begin offset = OFF_RD_LEN;  reg_data = DATA_W'(len);    end
    endcase
  end

  assign reg_addr = REG_BASE + ADDR_W'(offset);
endmodule

// File: rtl/dbs_delay.sv
module dbs_delay #(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  input  logic              en,
  output logic              expired
);
  logic [WAIT_W-1:0] cnt_q;
  logic [WAIT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (en && (cnt_q != '0))
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/dbs_axil_wr.sv
module dbs_axil_wr #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_data,
  output logic                wr_done,
  output logic [1:0]          wr_resp,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wvalid,
  input  logic                m_wready,
  input  logic [1:0]          m_bresp,
  input  logic                m_bvalid,
  output logic                m_bready
);
  localparam int STRB_W = DATA_W / 8;

  logic              awv_q, wv_q, pend_q;
  logic              awv_d, wv_d, pend_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              aw_fire, w_fire, b_fire;

  assign aw_fire = awv_q && m_awready;
  assign w_fire  = wv_q && m_wready;
  assign b_fire  = m_bready && m_bvalid;

  always_comb begin
    awv_d  = awv_q;
    wv_d   = wv_q;
    pend_d = pend_q;
    if (req) begin
      awv_d  = 1'b1;
      wv_d   = 1'b1;
      pend_d = 1'b1;
    end else begin
      if (aw_fire) awv_d  = 1'b0;
      if (w_fire)  wv_d   = 1'b0;
      if (b_fire)  pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      awv_q  <= 1'b0;
      wv_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      awv_q  <= awv_d;
      wv_q   <= wv_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk) begin
    if (req) begin
      addr_q <= req_addr;
      data_q <= req_data;
    end
  end

  assign m_awaddr  = addr_q;
  assign m_awvalid = awv_q;
  assign m_wdata   = data_q;
  assign m_wstrb   = {STRB_W{1'b1}};
  assign m_wvalid  = wv_q;
  assign m_bready  = pend_q && !awv_q && !wv_q;
  assign wr_done   = b_fire;
  assign wr_resp   = m_bresp;
endmodule

// File: rtl/dma_bringup_seq.sv
module dma_bringup_seq
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 26,
  parameter int WAIT_W = 8,
  parameter logic [ADDR_W-1:0] REG_BASE = 32'h4040_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [DATA_W-1:0]   src_addr,
  input  logic [DATA_W-1:0]   dst_addr,
  input  logic [LEN_W-1:0]    byte_len,
  input  logic [WAIT_W-1:0]   rst_wait,
  output logic                busy,
  output logic                done,
  output logic                error,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wvalid,
  input  logic                m_wready,
  input  logic [1:0]          m_bresp,
  input  logic                m_bvalid,
  output logic                m_bready
);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(N_STEPS - 1);
  localparam logic [STEP_W-1:0] STEP_RST  = STEP_W'(STEP_LAST_RST);

  seq_state_t        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              done_q, done_d;
  logic              cap_en, issue, dly_load, dly_expired;
  logic              wr_done;
  logic [1:0]        wr_resp;
  logic [DATA_W-1:0] src_q, dst_q;
  logic [LEN_W-1:0]  len_q;
  logic [ADDR_W-1:0] step_addr;
  logic [DATA_W-1:0] step_data;

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    done_d   = 1'b0;
    cap_en   = 1'b0;
    issue    = 1'b0;
    dly_load = 1'b0;
    case (state_q)
      ST_IDLE, ST_ERROR: begin
        if (start) begin
          state_d = ST_ISSUE;
          step_d  = '0;
          cap_en  = 1'b1;
        end
      end
      ST_ISSUE: begin
        issue   = 1'b1;
        state_d = ST_WAITB;
      end
      ST_WAITB: begin
        if (wr_done) begin
          if (wr_resp != RESP_OKAY) begin
            state_d = ST_ERROR;
          end else if (step_q == STEP_LAST) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            step_d = step_q + 1'b1;
            if (step_q == STEP_RST) begin
              dly_load = 1'b1;
              state_d  = ST_DELAY;
            end else begin
              state_d = ST_ISSUE;
            end
          end
        end
      end
      ST_DELAY: begin
        if (dly_expired) state_d = ST_ISSUE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      src_q <= src_addr;
      dst_q <= dst_addr;
      len_q <= byte_len;
    end
  end

  dbs_step_map #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .REG_BASE(REG_BASE)
  ) u_map (
    .step(step_q), .src(src_q), .dst(dst_q), .len(len_q),
    .reg_addr(step_addr), .reg_data(step_data)
  );

  dbs_delay #(.WAIT_W(WAIT_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .load(dly_load), .load_val(rst_wait),
    .en(state_q == ST_DELAY), .expired(dly_expired)
  );

  dbs_axil_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .req(issue), .req_addr(step_addr),
    .req_data(step_data), .wr_done(wr_done), .wr_resp(wr_resp),
    .m_awaddr(m_awaddr), .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid),
    .m_wready(m_wready), .m_bresp(m_bresp), .m_bvalid(m_bvalid),
    .m_bready(m_bready)
  );

  assign busy  = (state_q != ST_IDLE) && (state_q != ST_ERROR);
  assign done  = done_q;
  assign error = (state_q == ST_ERROR);
endmodule

// File: rtl/dbs_checker.sv
module dbs_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic [ADDR_W-1:0] m_awaddr,
  input logic              m_awvalid,
  input logic              m_awready,
  input logic [DATA_W-1:0] m_wdata,
  input logic              m_wvalid,
  input logic              m_wready,
  input logic [1:0]        m_bresp,
  input logic              m_bvalid,
  input logic              m_bready
);
  AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr)); // R6
  AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid && !m_wready |=> m_wvalid && $stable(m_wdata)); // R6
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    m_bready |-> !m_awvalid && !m_wvalid); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_AFTER_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(m_bvalid && m_bready) && !busy); // R7
  AST_ERR_ON_BAD_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    m_bvalid && m_bready && (m_bresp != 2'b00) |=> error && !done); // R8
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !busy && !m_awvalid && !m_wvalid); // R8
endmodule

bind dma_bringup_seq dbs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .error(error),
  .m_awaddr(m_awaddr), .m_awvalid(m_awvalid), .m_awready(m_awready),
  .m_wdata(m_wdata), .m_wvalid(m_wvalid), .m_wready(m_wready),
  .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready)
);

// File: tb/dma_bringup_seq_tb.sv
`timescale 1ns/1ps
module dma_bringup_seq_tb;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 26;
  localparam int WAIT_W = 8;
  localparam logic [31:0] BASE = 32'h4040_0000;

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] d;
  } wr_t;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic [31:0]       src_addr, dst_addr;
  logic [LEN_W-1:0]  byte_len;
  logic [WAIT_W-1:0] rst_wait;
  logic              busy, done, error;
  logic [31:0]       m_awaddr, m_wdata;
  logic [3:0]        m_wstrb;
  logic              m_awvalid, m_wvalid, m_bready;
  logic              m_awready, m_wready, m_bvalid;
  logic [1:0]        m_bresp;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  wr_t exp_q[$];

  // slave model state
  int aw_dly, w_dly, b_dly, err_at;
  int aw_cnt, w_cnt, b_cnt, wr_idx;
  bit aw_have, w_have, aw2_seen;
  int aw2_cyc, b1_cyc, last_b_cyc;
  logic [31:0] cap_a, cap_d;
  int done_cnt = 0;
  bit prev_done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dma_bringup_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .WAIT_W(WAIT_W), .REG_BASE(BASE)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr),
    .dst_addr(dst_addr), .byte_len(byte_len), .rst_wait(rst_wait),
    .busy(busy), .done(done), .error(error),
    .m_awaddr(m_awaddr), .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid),
    .m_wready(m_wready), .m_bresp(m_bresp), .m_bvalid(m_bvalid),
    .m_bready(m_bready)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string step_tag(input int i);
    if (i < 2) return "R2";
    if (i < 5) return "R4";
    return "R5";
  endfunction

  // AXI4-Lite slave model and monitor, active on falling edges
  always @(negedge clk) begin
    if (!rst_n) begin
      m_awready = 0; m_wready = 0; m_bvalid = 0; m_bresp = 2'b00;
      aw_have = 0; w_have = 0; aw_cnt = 0; w_cnt = 0; b_cnt = 0;
    end else begin
      if (m_bready && !(aw_have && w_have)) begin
        n_chk++; n_fail++;
        $display("FAIL R6: bready=1 before both channels accepted (aw=%0d w=%0d) expected 0", aw_have, w_have);
      end
      if (m_awready) m_awready = 0;
      else if (m_awvalid && !aw_have) begin
        if (wr_idx == 2 && !aw2_seen) begin aw2_seen = 1; aw2_cyc = cyc; end
        if (aw_cnt >= aw_dly) begin
          m_awready = 1; cap_a = m_awaddr; aw_have = 1; aw_cnt = 0;
        end else aw_cnt++;
      end
      if (m_wready) m_wready = 0;
      else if (m_wvalid && !w_have) begin
        if (w_cnt >= w_dly) begin
          m_wready = 1; cap_d = m_wdata; w_have = 1; w_cnt = 0;
          chk("R6 wstrb", m_wstrb, 4'hF);
        end else w_cnt++;
      end
      if (m_bvalid) m_bvalid = 0;
      else if (aw_have && w_have && !m_awready && !m_wready && m_bready) begin
        if (b_cnt >= b_dly) begin
          b_cnt = 0;
          m_bvalid = 1;
          m_bresp = (wr_idx == err_at) ? 2'b10 : 2'b00;
          last_b_cyc = cyc;
          if (wr_idx == 1) b1_cyc = cyc;
          if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL %s: unexpected write %0h<=%0h expected none", step_tag(wr_idx), cap_a, cap_d);
          end else begin
            wr_t e;
            e = exp_q.pop_front();
            chk(step_tag(wr_idx), {cap_a, cap_d}, {e.a, e.d});
          end
          aw_have = 0; w_have = 0;
          wr_idx++;
        end else b_cnt++;
      end
    end
  end

  // done pulse monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        done_cnt++;
        chk("R7 done timing", cyc, last_b_cyc + 1);
        chk("R7 busy at done", busy, 1'b0);
      end
      if (done && prev_done) begin
        n_chk++; n_fail++;
        $display("FAIL R7: done high %0d cycles expected 1", 2);
      end
      prev_done = done;
    end
  end

  task automatic push_exp(input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] l, input int upto);
    wr_t full[8];
    full[0] = '{BASE + 32'h00, 32'h4};
    full[1] = '{BASE + 32'h30, 32'h4};
    full[2] = '{BASE + 32'h48, d};
    full[3] = '{BASE + 32'h30, 32'h1};
    full[4] = '{BASE + 32'h58, l};
    full[5] = '{BASE + 32'h18, s};
    full[6] = '{BASE + 32'h00, 32'h1};
    full[7] = '{BASE + 32'h28, l};
    for (int i = 0; i < upto; i++) exp_q.push_back(full[i]);
  endtask

  task automatic run_seq(input logic [31:0] s, input logic [31:0] d, input int l,
                         input int w, input int ad, input int wd, input int bd, input int err);
    @(posedge clk); #1;
    aw_dly = ad; w_dly = wd; b_dly = bd; err_at = err;
    wr_idx = 0; aw2_seen = 0;
    push_exp(s, d, 32'(l), (err >= 0) ? err + 1 : 8);
    src_addr = s; dst_addr = d; byte_len = LEN_W'(l); rst_wait = WAIT_W'(w);
    start = 1;
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic wait_end(input int d0);
    int t = 0;
    while (done_cnt == d0 && !error && t < 5000) begin
      @(posedge clk); t++;
    end
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic finish_seq(input int w, input int d0);
    wait_end(d0);
    chk("R7 done count", done_cnt, d0 + 1);
    chk("R5 write count", wr_idx, 8);
    chk("R5 no leftover", exp_q.size(), 0);
    chk("R3 reset wait", aw2_cyc - b1_cyc, w + 3);
    chk("R7 busy after", busy, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R7: watchdog expired, actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int d0;
    rst_n = 0; start = 0; src_addr = 0; dst_addr = 0; byte_len = 0; rst_wait = 0;
    aw_dly = 0; w_dly = 0; b_dly = 0; err_at = -1; wr_idx = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 error", error, 0);
    chk("R1 awvalid", m_awvalid, 0);
    chk("R1 wvalid", m_wvalid, 0);
    chk("R1 bready", m_bready, 0);

    // T1: zero-delay slave
    d0 = done_cnt;
    run_seq(32'h1000_0000, 32'h2000_0000, 32, 3, 0, 0, 0, -1);
    finish_seq(3, d0);

    // T2: address channel slow, zero reset wait
    d0 = done_cnt;
    run_seq(32'h1000_0100, 32'h2000_0200, 1024, 0, 2, 0, 1, -1);
    finish_seq(0, d0);

    // T3: data channel slow, long wait, R9 re-start and input change mid-series
    d0 = done_cnt;
    run_seq(32'hAAAA_0000, 32'h5555_0000, 26'h3FF_FFFF, 7, 0, 3, 3, -1);
    while (wr_idx < 3) @(posedge clk);
    #1;
    src_addr = 32'hDEAD_BEEF; dst_addr = 32'hFEED_F00D; byte_len = 26'd4; rst_wait = 8'd50;
    start = 1;
    @(posedge clk); #1;
    start = 0;
    finish_seq(7, d0);
    chk("R9 busy after ignored start", busy, 0);

    // T4: error response on the write-channel run write (index 3)
    d0 = done_cnt;
    run_seq(32'h0000_1000, 32'h0000_2000, 64, 1, 1, 1, 0, 3);
    wait_end(d0);
    chk("R8 error", error, 1);
    chk("R8 busy", busy, 0);
    chk("R8 writes stop", wr_idx, 4);
    repeat (20) @(posedge clk);
    #1;
    chk("R8 still stopped", wr_idx, 4);
    chk("R8 still error", error, 1);
    chk("R8 no done", done_cnt, d0);
    chk("R8 no pending expected", exp_q.size(), 0);

    // T5: restart from error
    d0 = done_cnt;
    run_seq(32'h0BAD_0000, 32'h0C0D_0000, 7, 1, 1, 1, 0, -1);
    chk("R10 error cleared", error, 0);
    chk("R10 busy", busy, 1);
    finish_seq(1, d0);
    chk("R10 error stays low", error, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule